// File: doc/BRIEF.md
# Speculative Register Validity and Head Timeout Tracker

This block sits beside a consumer core that runs an injected, speculative instruction stream. It keeps one validity bit for each physical register, so the core can tell which values were computed from trustworthy inputs. When the core enters the speculative mode, a single pulse clears every bit. After that, validity returns only through instructions whose inputs are all valid. A load-immediate has no inputs, so it always counts as valid.

At issue, the block checks the enabled source operands against the validity bits. If any source is invalid, the instruction is flagged as suppressed, and its destination becomes invalid instead of valid. The block also watches the reorder-buffer head. A long-latency load that stays there without completing for a fixed number of cycles is flagged for forced retirement, and its destination register is marked invalid. This keeps the pipeline from stalling while still blocking its dependents.

Renaming, scheduling and execution live outside the block. They are represented by the issue and head ports.

Top module: `spec_reg_validity`

## Requirements
- R1: After reset every bit of `reg_valid` is 0 and `force_retire` is 0.
- R2: A cycle with `mode_enter` high makes all bits of `reg_valid` 0 from the next cycle on. This takes precedence over any issue or forced retirement in the same cycle.
- R3: `iss_suppress` is high in the same cycle if and only if `iss_req` is high and at least one source whose bit in `iss_src_en` is 1 names a register whose `reg_valid` bit is 0. Source i occupies bits [i*IDXW +: IDXW] of `iss_src`.
- R4: An issue with `iss_dst_en` high sets bit `iss_dst` of `reg_valid` in the next cycle to the inverse of `iss_suppress`. Bits other than the destination are left unchanged.
- R5: An issue with all bits of `iss_src_en` at 0 (a load-immediate) always makes its destination valid.
- R6: `force_retire` rises exactly TIMEOUT cycles after the cycle in which `head_new` was high, provided `head_vld` and `head_ll` stayed high and `head_done` stayed low. It stays high for one cycle only.
- R7: `force_retire` stays low while the head is not a long-latency load (`head_ll` low) or once `head_done` is high.
- R8: A cycle with `force_retire` high makes bit `head_dst` of `reg_valid` 0 in the next cycle.
- R9: If `force_retire` invalidates the same register that an issue would set valid in the same cycle, the register ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_enter | input | 1 | Pulse on entry to the speculative mode; clears all validity |
| iss_req | input | 1 | An instruction issues this cycle |
| iss_src_en | input | NSRC | Per-source operand present |
| iss_src | input | NSRC*IDXW | Packed source register indices |
| iss_dst_en | input | 1 | Instruction writes a destination |
| iss_dst | input | IDXW | Destination register index |
| iss_suppress | output | 1 | Issued instruction reads an invalid register |
| head_vld | input | 1 | ROB head holds an instruction |
| head_new | input | 1 | A new instruction reached the ROB head this cycle |
| head_ll | input | 1 | Head is a long-latency load |
| head_done | input | 1 | Head has completed |
| head_dst | input | IDXW | Destination register of the head |
| force_retire | output | 1 | Head must be retired by force this cycle |
| reg_valid | output | NUM_PREGS | Validity bit per physical register |

## Verification
The hardest case to reach from the ports is a forced retirement that lands in the same cycle as an issue writing the same register, with that register already valid beforehand. The stimulus first makes the register valid with a load-immediate. It then starts a head load at a known cycle, counts exactly TIMEOUT cycles, and issues a load-immediate to that register in the firing cycle. Random issue streams with occasional mode-entry pulses cover suppression chains, and directed head scenarios cover early completion and non-load heads.

// File: rtl/srv_pkg.sv
package srv_pkg;
  localparam int unsigned SRV_DEF_PREGS   = 32;
  localparam int unsigned SRV_DEF_NSRC    = 2;
  localparam int unsigned SRV_DEF_TIMEOUT = 12;

  // Head-timer condition: waiting on an incomplete long-latency load
  typedef enum logic [0:0] {
    HD_IDLE = 1'b0,
    HD_WAIT = 1'b1
  } hd_state_e;
endpackage

// File: rtl/srv_src_check.sv
module srv_src_check #(
  parameter int unsigned NUM_PREGS = 32,
  parameter int unsigned NSRC      = 2,
  localparam int unsigned IDXW     = $clog2(NUM_PREGS)
) (
  input  logic                 req,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC*IDXW-1:0] src,
  input  logic [NUM_PREGS-1:0] valid,
  output logic                 suppress
);
  logic [NSRC-1:0] bad;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      bad[i] = src_en[i] & ~valid[src[i*IDXW +: IDXW]];
    end
  end

  always_comb begin
    suppress = req & (|bad);
  end
endmodule

// File: rtl/srv_valid_file.sv
module srv_valid_file #(
  parameter int unsigned NUM_PREGS = 32,
  localparam int unsigned IDXW     = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flash_clr,
  input  logic                 set_en,
  input  logic [IDXW-1:0]      set_idx,
  input  logic                 set_val,
  input  logic                 kill_en,
  input  logic [IDXW-1:0]      kill_idx,
  output logic [NUM_PREGS-1:0] valid
);
  logic [NUM_PREGS-1:0] valid_q, valid_d;
  logic                 upd_en;

  always_comb begin
    valid_d = valid_q;
    if (set_en)    valid_d[set_idx]  = set_val;
    if (kill_en)   valid_d[kill_idx] = 1'b0;   // forced retirement wins
    if (flash_clr) valid_d = '0;               // mode entry wins over all
    upd_en = flash_clr | set_en | kill_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (upd_en) valid_q <= valid_d;
  end

  assign valid = valid_q;

  AST_FLASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flash_clr |=> (valid_q == '0)); // R2

  AST_KILL_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |=> !valid_q[$past(kill_idx)]); // R8

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flash_clr && !(kill_en && kill_idx == set_idx))
      |=> (valid_q[$past(set_idx)] == $past(set_val))); // R4

  AST_KILL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_val && kill_en && kill_idx == set_idx)
      |=> !valid_q[$past(set_idx)]); // R9
endmodule

// File: rtl/srv_head_timer.sv
module srv_head_timer
  import srv_pkg::*;
#(
  parameter int unsigned TIMEOUT = SRV_DEF_TIMEOUT,
  localparam int unsigned CW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic head_vld,
  input  logic head_new,
  input  logic head_ll,
  input  logic head_done,
  output logic fire
);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

  hd_state_e     cond;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cond   = (head_vld & head_ll & ~head_done) ? HD_WAIT : HD_IDLE;
    fire   = (cond == HD_WAIT) & ~head_new & (cnt_q == LIMIT);
    cnt_en = 1'b1;
    if (head_new || fire || cond == HD_IDLE) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire); // R6

  AST_FIRE_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (head_vld && head_ll && !head_done)); // R7
endmodule

// File: rtl/spec_reg_validity.sv
module spec_reg_validity
  import srv_pkg::*;
#(
  parameter int unsigned NUM_PREGS = SRV_DEF_PREGS,
  parameter int unsigned NSRC      = SRV_DEF_NSRC,
  parameter int unsigned TIMEOUT   = SRV_DEF_TIMEOUT,
  localparam int unsigned IDXW     = $clog2(NUM_PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_enter,
  input  logic                 iss_req,
  input  logic [NSRC-1:0]      iss_src_en,
  input  logic [NSRC*IDXW-1:0] iss_src,
  input  logic                 iss_dst_en,
  input  logic [IDXW-1:0]      iss_dst,
  output logic                 iss_suppress,
  input  logic                 head_vld,
  input  logic                 head_new,
  input  logic                 head_ll,
  input  logic                 head_done,
  input  logic [IDXW-1:0]      head_dst,
  output logic                 force_retire,
  output logic [NUM_PREGS-1:0] reg_valid
);
  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic set_en;

  assign set_en = iss_req & iss_dst_en;

  srv_src_check #(.NUM_PREGS(NUM_PREGS), .NSRC(NSRC)) u_chk (
    .req      (iss_req),
    .src_en   (iss_src_en),
    .src      (iss_src),
    .valid    (reg_valid),
    .suppress (iss_suppress)
  );

  srv_head_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .head_vld  (head_vld),
    .head_new  (head_new),
    .head_ll   (head_ll),
    .head_done (head_done),
    .fire      (force_retire)
  );

  srv_valid_file #(.NUM_PREGS(NUM_PREGS)) u_vf (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .flash_clr (mode_enter),
    .set_en    (set_en),
    .set_idx   (iss_dst),
    .set_val   (~iss_suppress),
    .kill_en   (force_retire),
    .kill_idx  (head_dst),
    .valid     (reg_valid)
  );

  AST_LOADIMM_VALID: assert property (@(posedge clk) disable iff (!rst_core_n)
    (set_en && iss_src_en == '0 && !mode_enter && !force_retire)
      |=> reg_valid[$past(iss_dst)]); // R5

  AST_SUPPRESS_DST: assert property (@(posedge clk) disable iff (!rst_core_n)
    (set_en && iss_suppress) |=> !reg_valid[$past(iss_dst)]); // R4
endmodule

// File: tb/spec_reg_validity_tb.sv
`timescale 1ns/1ps
module spec_reg_validity_tb;
  localparam int NP = 32;
  localparam int NS = 2;
  localparam int TO = 12;
  localparam int IW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_n;
  logic mode_enter, iss_req, iss_dst_en, head_vld, head_new, head_ll, head_done;
  logic [NS-1:0]    iss_src_en;
  logic [NS*IW-1:0] iss_src;
  logic [IW-1:0]    iss_dst, head_dst;
  logic             iss_suppress, force_retire;
  logic [NP-1:0]    reg_valid;

  logic [NP-1:0] exp_v;
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  spec_reg_validity u_dut (
    .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .iss_req(iss_req),
    .iss_src_en(iss_src_en), .iss_src(iss_src), .iss_dst_en(iss_dst_en),
    .iss_dst(iss_dst), .iss_suppress(iss_suppress), .head_vld(head_vld),
    .head_new(head_new), .head_ll(head_ll), .head_done(head_done),
    .head_dst(head_dst), .force_retire(force_retire), .reg_valid(reg_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic bit exp_sup(input logic [NS-1:0] en, input logic [NS*IW-1:0] s,
                                 input logic [NP-1:0] v);
    bit r = 1'b0;
    for (int i = 0; i < NS; i++)
      if (en[i] && !v[s[i*IW +: IW]]) r = 1'b1;
    return r;
  endfunction

  task automatic idle();
    mode_enter = 0; iss_req = 0; iss_src_en = '0; iss_src = '0;
    iss_dst_en = 0; iss_dst = '0; head_vld = 0; head_new = 0;
    head_ll = 0; head_done = 0; head_dst = '0;
  endtask

  task automatic load_imm(input int d);
    @(negedge clk);
    idle();
    iss_req = 1; iss_dst_en = 1; iss_dst = IW'(d);
    #1 chk(iss_suppress == 1'b0, "R5 loadimm suppress", 64'(iss_suppress), 0);
    exp_v[d] = 1'b1;
    @(negedge clk);
    idle();
    chk(reg_valid[d] == 1'b1, "R5 loadimm valid", 64'(reg_valid[d]), 1);
  endtask

  // done_at: cycle at which head_done rises (0 = never)
  task automatic head_run(input int d, input bit is_ll, input int done_at, input bit collide);
    bit fire_exp;
    @(negedge clk);
    idle();
    head_vld = 1; head_ll = is_ll; head_new = 1; head_dst = IW'(d);
    for (int k = 1; k <= TO + 1; k++) begin
      @(negedge clk);
      head_new = 0;
      iss_req = 0; iss_dst_en = 0;
      if (done_at != 0 && k >= done_at) head_done = 1;
      if (collide && k == TO) begin
        iss_req = 1; iss_dst_en = 1; iss_dst = IW'(d); iss_src_en = '0;
      end
      #1;
      fire_exp = is_ll && done_at == 0 && k == TO;
      chk(force_retire == fire_exp, is_ll && done_at == 0 ? "R6 timeout" : "R7 no force",
          64'(force_retire), 64'(fire_exp));
      if (k == TO) begin
        if (collide) exp_v[d] = 1'b1;
        if (fire_exp) exp_v[d] = 1'b0;
      end
    end
    idle();
    chk(reg_valid == exp_v, collide ? "R9 kill wins" : "R8 force invalidates",
        64'(reg_valid), 64'(exp_v));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit s;
    void'($urandom(32'h5EED_0042));
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    exp_v = '0;
    chk(reg_valid == '0, "R1 reset valid", 64'(reg_valid), 0);
    chk(force_retire == 1'b0, "R1 reset force", 64'(force_retire), 0);

    // Dependent chain: invalid source suppresses, then valid source passes
    @(negedge clk);
    iss_req = 1; iss_src_en = 2'b01; iss_src = {IW'(0), IW'(3)};
    iss_dst_en = 1; iss_dst = IW'(4);
    #1 chk(iss_suppress == 1'b1, "R3 invalid src", 64'(iss_suppress), 1);
    @(negedge clk); idle();
    chk(reg_valid[4] == 1'b0, "R4 suppressed dst invalid", 64'(reg_valid[4]), 0);
    load_imm(3);
    load_imm(5);
    @(negedge clk);
    iss_req = 1; iss_src_en = 2'b11; iss_src = {IW'(5), IW'(3)};
    iss_dst_en = 1; iss_dst = IW'(4);
    #1 chk(iss_suppress == 1'b0, "R3 valid srcs", 64'(iss_suppress), 0);
    exp_v[4] = 1'b1;
    @(negedge clk); idle();
    chk(reg_valid == exp_v, "R4 dst valid", 64'(reg_valid), 64'(exp_v));

    // Head timer corner cases
    load_imm(7);
    head_run(7, 1'b1, 0, 1'b0);   // exact timeout
    load_imm(7);
    head_run(7, 1'b1, 5, 1'b0);   // completes early
    head_run(7, 1'b0, 0, 1'b0);   // not a load
    head_run(7, 1'b1, TO, 1'b0);  // completes in firing cycle
    load_imm(9);
    head_run(9, 1'b1, 0, 1'b1);   // collision with valid-making issue

    // Mode entry collides with a load-immediate
    @(negedge clk);
    mode_enter = 1; iss_req = 1; iss_dst_en = 1; iss_dst = IW'(2);
    exp_v = '0;
    @(negedge clk); idle();
    chk(reg_valid == '0, "R2 flash clear wins", 64'(reg_valid), 0);

    // Random issue stream
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      chk(reg_valid == exp_v, "R4 random state", 64'(reg_valid), 64'(exp_v));
      idle();
      mode_enter = ($urandom_range(0, 59) == 0);
      iss_req    = ($urandom_range(0, 3) != 0);
      iss_dst_en = ($urandom_range(0, 4) != 0);
      iss_dst    = IW'($urandom_range(0, 7));
      iss_src_en = ($urandom_range(0, 2) == 0) ? '0 : NS'($urandom);
      for (int i = 0; i < NS; i++) iss_src[i*IW +: IW] = IW'($urandom_range(0, 7));
      #1;
      s = iss_req && exp_sup(iss_src_en, iss_src, exp_v);
      chk(iss_suppress == s, "R3 random suppress", 64'(iss_suppress), 64'(s));
      if (iss_req && iss_dst_en) exp_v[iss_dst] = !s;
      if (mode_enter) exp_v = '0;
    end
    @(negedge clk);
    chk(reg_valid == exp_v, "R2 final state", 64'(reg_valid), 64'(exp_v));
    idle();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule